// File: doc/BRIEF.md
# Shared-Link Reconfiguration Data Diverter

This block lets one existing 32-bit data link carry two kinds of traffic at different times: partial-reconfiguration words bound for an internal configuration port, and the normal payload bound for the user datapath. A host uses a small register path to load a word count and then to arm a session. While a session is open, every valid link word is steered to the configuration port, which receives a data bus and active-low enable and write strobes. During the session the user datapath is held in a stall and sees no valid words.

When the programmed number of words has been written to the port, the block raises a one-cycle done pulse, closes the session and lets the user logic sample the link again. If no session is armed, or the host arms one with a count of zero, payload goes straight through to the user logic and the port stays quiet. Arming a second time while a session is open is refused and recorded in a sticky error bit. The port and the user logic share one clock, so one word per cycle can be diverted with no rate buffering.

Top module: `link_cfg_diverter`

## Requirements
- R1: After reset, cfg_ce_n and cfg_we_n are high, usr_hold is low, done_pulse is low, and the status register (address 2) reads 0.
- R2: A write to address 1 stores the session word count (low 16 bits) and reads back from address 1; a write to address 0 with bit 0 set arms a session, so from the next cycle usr_hold is high.
- R3: While a session is open (from arming until the cycle after done_pulse), usr_valid stays low whatever arrives on the link.
- R4: Each valid link word accepted during a session appears on cfg_data with cfg_ce_n and cfg_we_n both low exactly one cycle later; both strobes stay high on every cycle that carries no diverted word, including gaps and back-to-back streams.
- R5: After exactly the programmed number of diverted words, done_pulse is high for one cycle, in the same cycle as the last word's strobe; the cycle after, the session is closed.
- R6: With no session open, usr_valid follows link_valid and usr_data equals link_data in the same cycle, and the configuration strobes stay high.
- R7: Arming with a stored count of zero opens no session: usr_hold stays low and payload keeps passing.
- R8: An arm request while a session is open is ignored (the session still ends after the original count) and sets status bit 1, which stays set until a write to address 2 with bit 1 set clears it.
- R9: Status bit 0 (address 2) reads 1 while a session is open and 0 otherwise.
- R10: usr_hold is high on every cycle the configuration strobes are active.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of link, port and user logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 count, 2 status) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data for reg_addr |
| link_valid | input | 1 | Shared link word valid |
| link_data | input | 32 | Shared link word |
| usr_valid | output | 1 | Payload word valid toward user logic |
| usr_data | output | 32 | Payload word toward user logic |
| usr_hold | output | 1 | Stall for the user pipeline during a session |
| cfg_ce_n | output | 1 | Configuration port enable, active low |
| cfg_we_n | output | 1 | Configuration port write, active low |
| cfg_data | output | 32 | Configuration port data |
| done_pulse | output | 1 | One-cycle pulse with the last configuration write |

## Verification
The bench goes after the session end: a counter that stops one word early leaves the last word on the user side and shifts the done pulse, and one that stops late swallows the first payload word. It streams words both with gaps and back to back, so a driver that strobes on idle cycles or merges adjacent words sends extra or missing items to the port scoreboard. An arm request in mid-session must neither restart the count nor go unrecorded, and a zero count must not leave the user logic stalled forever.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    SS_IDLE  = 2'd0,
    SS_ARMED = 2'd1,
    SS_XFER  = 2'd2,
    SS_DONE  = 2'd3
  } sess_t;

  typedef enum logic {
    DS_IDLE  = 1'b0,
    DS_WRITE = 1'b1
  } drv_t;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_COUNT  = 1;
  localparam int unsigned ADDR_STATUS = 2;
  localparam int unsigned BIT_ARM     = 0;
  localparam int unsigned BIT_BUSY    = 0;
  localparam int unsigned BIT_ERR     = 1;
endpackage

// File: rtl/lnk_regs.sv
module lnk_regs #(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 16,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               busy,
  input  logic               arm_reject,
  output logic               arm_req,
  output logic [COUNT_W-1:0] count_q,
  output logic [DATA_W-1:0]  rd_data
);
  import lnk_pkg::*;

  logic               count_en;
  logic [COUNT_W-1:0] count_d;
  logic               err_q;
  logic               err_d;
  logic               err_clr;

  always_comb begin
    count_en = wr_en && (addr == ADDR_W'(ADDR_COUNT));
    count_d  = wr_data[COUNT_W-1:0];
    arm_req  = wr_en && (addr == ADDR_W'(ADDR_CTRL)) && wr_data[BIT_ARM];
    err_clr  = wr_en && (addr == ADDR_W'(ADDR_STATUS)) && wr_data[BIT_ERR];
    err_d    = arm_reject | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      ADDR_W'(ADDR_COUNT):  rd_data = DATA_W'(count_q);
      ADDR_W'(ADDR_STATUS): begin
        rd_data[BIT_BUSY] = busy;
        rd_data[BIT_ERR]  = err_q;
      end
      default:              rd_data = '0;
    endcase
  end

  // R8: a refused arm request is recorded on the next cycle
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    arm_reject |=> err_q);

  // R8: the error bit only falls through an explicit clear
  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/lnk_session.sv
module lnk_session #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_req,
  input  logic [COUNT_W-1:0] count_q,
  input  logic               link_valid,
  output logic               take,
  output logic               busy,
  output logic               done_pulse,
  output logic               arm_reject
);
  import lnk_pkg::*;

  sess_t              st_q;
  sess_t              st_d;
  logic [COUNT_W-1:0] rem_q;
  logic [COUNT_W-1:0] rem_d;
  logic               rem_en;
  logic               start;
  logic               last;

  always_comb begin
    busy       = (st_q != SS_IDLE);
    take       = link_valid && ((st_q == SS_ARMED) || (st_q == SS_XFER));
    start      = (st_q == SS_IDLE) && arm_req && (count_q != '0);
    arm_reject = arm_req && busy;
    last       = (rem_q == COUNT_W'(1));
    done_pulse = (st_q == SS_DONE);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      SS_IDLE:  if (start) st_d = SS_ARMED;
      SS_ARMED,
      SS_XFER:  if (take) st_d = last ? SS_DONE : SS_XFER;
      SS_DONE:  st_d = SS_IDLE;
      default:  st_d = SS_IDLE;
    endcase
  end

  always_comb begin
    rem_en = start || take;
    rem_d  = start ? count_q : (rem_q - COUNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  // R5: the done indication lasts a single cycle and closes the session
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!done_pulse && !busy));

  // R7: a zero count opens nothing
  a_r7_zero_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && arm_req && (count_q == '0)) |=> !busy);

  // R8: an arm request inside a session leaves the remaining count alone
  a_r8_arm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_reject && !take && (st_q != SS_DONE)) |=> $stable(rem_q));
endmodule

// File: rtl/lnk_cfg_drive.sv
module lnk_cfg_drive #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] word,
  output logic              cfg_ce_n,
  output logic              cfg_we_n,
  output logic [DATA_W-1:0] cfg_data
);
  import lnk_pkg::*;

  drv_t              ds_q;
  drv_t              ds_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    ds_d = take ? DS_WRITE : DS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q <= DS_IDLE;
    end else begin
      ds_q <= ds_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take) begin
      data_q <= word;
    end
  end

  always_comb begin
    cfg_ce_n = (ds_q != DS_WRITE);
    cfg_we_n = (ds_q != DS_WRITE);
    cfg_data = data_q;
  end

  // R4: an accepted word reaches the port with its strobes one cycle later
  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!cfg_ce_n && !cfg_we_n && (cfg_data == $past(word))));

  // R4: no strobe without a word accepted the cycle before
  a_r4_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (cfg_ce_n && cfg_we_n));
endmodule

// File: rtl/link_cfg_diverter.sv
module link_cfg_diverter #(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 16,
  parameter int ADDR_W  = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              link_valid,
  input  logic [DATA_W-1:0] link_data,
  output logic              usr_valid,
  output logic [DATA_W-1:0] usr_data,
  output logic              usr_hold,
  output logic              cfg_ce_n,
  output logic              cfg_we_n,
  output logic [DATA_W-1:0] cfg_data,
  output logic              done_pulse
);
  logic [SYNC_N-1:0]  rst_sync_q;
  logic               rst_int_n;
  logic               arm_req;
  logic               arm_reject;
  logic               busy;
  logic               take;
  logic [COUNT_W-1:0] count_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_N-1];

  lnk_regs #(
    .DATA_W (DATA_W),
    .COUNT_W(COUNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wr_data   (reg_wr_data),
    .busy      (busy),
    .arm_reject(arm_reject),
    .arm_req   (arm_req),
    .count_q   (count_q),
    .rd_data   (reg_rd_data)
  );

  lnk_session #(
    .COUNT_W(COUNT_W)
  ) u_session (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .arm_req   (arm_req),
    .count_q   (count_q),
    .link_valid(link_valid),
    .take      (take),
    .busy      (busy),
    .done_pulse(done_pulse),
    .arm_reject(arm_reject)
  );

  lnk_cfg_drive #(
    .DATA_W(DATA_W)
  ) u_drive (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .take    (take),
    .word    (link_data),
    .cfg_ce_n(cfg_ce_n),
    .cfg_we_n(cfg_we_n),
    .cfg_data(cfg_data)
  );

  always_comb begin
    usr_hold  = busy;
    usr_valid = link_valid && !busy;
    usr_data  = link_data;
  end

  // R3: the user side sees nothing while a session is open
  a_r3_user_blind: assert property (@(posedge clk) disable iff (!rst_int_n)
    usr_hold |-> !usr_valid);

  // R10: the user pipeline is stalled whenever the port is written
  a_r10_hold_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_we_n |-> usr_hold);

  // R5: the done pulse coincides with a port write
  a_r5_done_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_pulse |-> (!cfg_we_n && !cfg_ce_n));
endmodule

// File: tb/link_cfg_diverter_tb.sv
`timescale 1ns/1ps
module link_cfg_diverter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic        link_valid;
  logic [31:0] link_data;
  logic        usr_valid;
  logic [31:0] usr_data;
  logic        usr_hold;
  logic        cfg_ce_n;
  logic        cfg_we_n;
  logic [31:0] cfg_data;
  logic        done_pulse;

  int total = 0;
  int bad   = 0;
  int dones = 0;
  logic [31:0] cfg_q[$];
  logic [31:0] usr_q[$];

  always #2.5 clk = ~clk;

  link_cfg_diverter u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .link_valid(link_valid), .link_data(link_data),
    .usr_valid(usr_valid), .usr_data(usr_data), .usr_hold(usr_hold),
    .cfg_ce_n(cfg_ce_n), .cfg_we_n(cfg_we_n), .cfg_data(cfg_data),
    .done_pulse(done_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic [31:0] exp,
                          input string req);
    reg_addr = a;
    #0.5;
    check(reg_rd_data == exp, req, reg_rd_data, exp);
  endtask

  // driver: one link word, its expected destination pushed to a queue
  task automatic send_word(input logic [31:0] d, input bit to_cfg);
    link_valid = 1'b1; link_data = d;
    if (to_cfg) cfg_q.push_back(d);
    else usr_q.push_back(d);
    tick();
    link_valid = 1'b0;
  endtask

  // monitor: port writes and user words compared against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_we_n || !cfg_ce_n) begin
        if (cfg_q.size() == 0) begin
          check(1'b0, "R4 unexpected port strobe", cfg_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = cfg_q.pop_front();
          check(cfg_data == e && !cfg_we_n && !cfg_ce_n, "R4 port word", cfg_data, e);
          check(usr_hold, "R10 hold during port write", {31'b0, usr_hold}, 32'h1);
        end
      end
      if (usr_valid) begin
        if (usr_q.size() == 0) begin
          check(1'b0, "R3 user word while diverting", usr_data, 32'h0);
        end else begin
          logic [31:0] e;
          e = usr_q.pop_front();
          check(usr_data == e, "R6 payload word", usr_data, e);
        end
      end
      if (done_pulse) dones++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wr_data = '0;
    link_valid = 1'b0; link_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    check(cfg_ce_n && cfg_we_n, "R1 strobes idle", {30'b0, cfg_ce_n, cfg_we_n}, 32'h3);
    check(!usr_hold && !done_pulse, "R1 hold/done low", {30'b0, usr_hold, done_pulse}, 32'h0);
    reg_read(2'd2, 32'h0, "R1 status zero");

    // R6 passthrough with no session
    for (int i = 0; i < 4; i++) send_word(32'hA000_0000 + i, 1'b0);
    tick();
    check(usr_q.size() == 0, "R6 payload delivered", usr_q.size(), 0);

    // R2 count register
    reg_write(2'd1, 32'd5);
    reg_read(2'd1, 32'd5, "R2 count readback");
    reg_write(2'd0, 32'h1);
    check(usr_hold, "R2 hold after arm", {31'b0, usr_hold}, 32'h1);
    reg_read(2'd2, 32'h1, "R9 busy set");

    // session with gaps, plus a refused arm mid-way
    send_word(32'hC0DE_0001, 1'b1);
    tick();
    send_word(32'hC0DE_0002, 1'b1);
    reg_write(2'd0, 32'h1);
    reg_read(2'd2, 32'h3, "R8 err set, still busy");
    send_word(32'hC0DE_0003, 1'b1);
    tick(); tick();
    send_word(32'hC0DE_0004, 1'b1);
    check(!done_pulse, "R5 no done before last word", {31'b0, done_pulse}, 32'h0);
    send_word(32'hC0DE_0005, 1'b1);
    check(done_pulse, "R5 done with last strobe", {31'b0, done_pulse}, 32'h1);
    check(usr_hold, "R3 hold through done cycle", {31'b0, usr_hold}, 32'h1);
    tick();
    check(!usr_hold && !done_pulse, "R5 session closed", {30'b0, usr_hold, done_pulse}, 32'h0);
    reg_read(2'd2, 32'h2, "R9 busy clear, R8 err sticky");
    check(cfg_q.size() == 0, "R8 session ended on original count", cfg_q.size(), 0);

    // first payload after session
    send_word(32'hBEEF_0000, 1'b0);
    send_word(32'hBEEF_0001, 1'b0);
    tick();
    check(usr_q.size() == 0, "R5 payload after session", usr_q.size(), 0);

    // R8 clear error
    reg_write(2'd2, 32'h2);
    reg_read(2'd2, 32'h0, "R8 err cleared");

    // R7 zero count
    reg_write(2'd1, 32'd0);
    reg_write(2'd0, 32'h1);
    check(!usr_hold, "R7 no hold on zero count", {31'b0, usr_hold}, 32'h0);
    reg_read(2'd2, 32'h0, "R7 not busy");
    send_word(32'h7777_0000, 1'b0);
    tick();
    check(usr_q.size() == 0, "R7 payload passes", usr_q.size(), 0);

    // R4 back-to-back session of three words
    reg_write(2'd1, 32'd3);
    reg_write(2'd0, 32'h1);
    send_word(32'h1111_1111, 1'b1);
    send_word(32'h2222_2222, 1'b1);
    send_word(32'h3333_3333, 1'b1);
    check(done_pulse, "R5 done back-to-back", {31'b0, done_pulse}, 32'h1);
    tick();
    check(!usr_hold, "R5 released", {31'b0, usr_hold}, 32'h0);
    send_word(32'h4444_4444, 1'b0);
    tick(); tick();
    check(cfg_q.size() == 0 && usr_q.size() == 0, "R4 scoreboard empty",
          cfg_q.size() + usr_q.size(), 0);
    check(dones == 2, "R5 done count", dones, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule